// File: doc/BRIEF.md
# Mains-loss transfer controller

This block decides when an emergency luminaire moves from mains to battery power and measures how well that move went. A raw comparator bit that says whether mains is valid is synchronised and filtered into a clean line-ok level. Separate filter lengths apply to a loss and to a return. The block then sequences five operating modes: normal, standby, emergency, self-test and fault. It drives the transfer and inverter enables for the power stage.

When a filtered mains loss occurs, the block records the millisecond timestamp and starts a transfer window. During the window it watches sampled LED current and bus voltage. The transfer counts as finished only after the LED current has stayed inside a stable band for a full hold time. The block then reports the delay from the loss to the start of that stable run, together with the lowest bus sample seen in the window. A self-test request runs the same qualification with mains still present. Protection flags and a window that never settles latch sticky fault bits that force a safe idle. A separate counter records bus brownout events.

Top module: `xfer_ctrl`

## Requirements
- R1: A drop of the raw mains input sets line_ok low only after the synchronised input has stayed low for DOWN_MS millisecond ticks. A shorter dip leaves line_ok and the mode unchanged.
- R2: A return of the raw input sets line_ok high only after UP_MS ticks of steady high input. This count is independent of DOWN_MS.
- R3: After reset the outputs are as follows: mode = 1 (standby), line_ok, xfer_en, inv_en and xfer_valid are low, and fault_bits, brownout_cnt, transfer_ms and vbus_min are zero.
- R4: Mode codes are normal = 0, standby = 1, emergency = 2, self-test = 3 and fault = 4. Standby moves to normal when line_ok is high. Normal moves to emergency when line_ok falls. In emergency and self-test, xfer_en and inv_en are high.
- R5: A transfer completes only when iled*100 >= iled_target*STABLE_PCT holds on every cycle for HOLD_MS ticks. A shorter excursion into the band does not count. On completion, xfer_valid rises and transfer_ms holds the ms timestamp at the start of the qualifying run minus the timestamp at the loss. The ms timestamp saturates and does not wrap.
- R6: vbus_min reports the lowest vbus sample from the start of the window to its completion.
- R7: Emergency returns to normal only after the restore debounce. Mains chatter shorter than UP_MS keeps the block in emergency.
- R8: test_req starts a self-test only in normal mode. It is ignored while line_ok is low and while in emergency. A self-test that reaches the stable band returns to normal and reports transfer_ms.
- R9: prot_flags bits 0..3 (undervoltage, overvoltage, overcurrent, overtemperature) latch into fault_bits at the same positions and force mode 4 with both enables low. A mains loss while in fault does not start a transfer.
- R10: If the band is not held within MAX_XFER_MS ticks of the window start, fault_bits bit 4 (timeout) is set and the mode becomes fault.
- R11: fault_bits stay set until fault_clr is asserted while prot_flags is zero. A clear while any flag is active is ignored. After a clear the mode is standby, and it becomes normal if line_ok is high.
- R12: brownout_cnt increments once for each transition of vbus from at or above BROWN_LVL to below it, and saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mains_raw | input | 1 | Unfiltered mains-valid comparator bit |
| iled | input | SAMP_W | Sampled LED current |
| iled_target | input | SAMP_W | Emergency LED current target |
| vbus | input | SAMP_W | Sampled bus voltage |
| prot_flags | input | 4 | Protection events: UV, OV, OCP, OTP at bits 0..3 |
| test_req | input | 1 | Self-test request |
| fault_clr | input | 1 | Fault latch clear |
| line_ok | output | 1 | Debounced mains-valid |
| xfer_en | output | 1 | Transfer switch enable |
| inv_en | output | 1 | Inverter enable |
| mode | output | 3 | Operating mode code |
| transfer_ms | output | TS_W | Measured transfer delay in ms |
| xfer_valid | output | 1 | transfer_ms and vbus_min hold a completed result |
| vbus_min | output | SAMP_W | Lowest bus sample in the last window |
| brownout_cnt | output | BO_W | Saturating brownout event count |
| fault_bits | output | 5 | Latched faults: protection bits 0..3, timeout bit 4 |

## Verification
The hardest case to reach is a transfer that sees an early current spike into the band, then current just below the threshold, and only later a genuine stable run. A loose qualifier would report the early spike, so the reported delay would be wrong. The stimulus paces each step in whole milliseconds from the moment emergency mode is observed. It holds the current one code below the band, then gives a spike shorter than the hold time, then holds exactly at the threshold. Only that last run may produce a result, and the scoreboard compares it with a one-millisecond tolerance. Timeout and restore chatter are reached the same way, by holding inputs across chosen numbers of millisecond ticks.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL  = 3'd0,
    MODE_STANDBY = 3'd1,
    MODE_EMERG   = 3'd2,
    MODE_TEST    = 3'd3,
    MODE_FAULT   = 3'd4
  } mode_t;

  localparam int FAULT_W = 5;
  localparam int FB_TMO  = 4;

  // stable-band test: sample is at or above pct percent of target
  function automatic logic band_ok(input logic [31:0] i, input logic [31:0] t,
                                   input logic [31:0] pct);
    return (i * 32'd100) >= (t * pct);
  endfunction

endpackage

// File: rtl/xfer_msclk.sv
module xfer_msclk #(
  parameter int TICK_DIV = 125000,
  parameter int TS_W     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            tick,
  output logic [TS_W-1:0] ms_now
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0] div_q;

  assign tick = (div_q == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ms_now <= '0;
    end else if (tick) begin
      div_q <= '0;
      if (ms_now != '1) ms_now <= ms_now + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  AST_MS_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ms_now >= $past(ms_now)); // R5

endmodule

// File: rtl/xfer_debounce.sv
module xfer_debounce #(
  parameter int DOWN_MS = 20,
  parameter int UP_MS   = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic line_ok
);
  localparam int LIM_MAX = (DOWN_MS > UP_MS) ? DOWN_MS : UP_MS;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  logic [1:0]       sync_q;
  logic             raw_s;
  logic [CNT_W-1:0] cnt_q, cnt_inc, lim;
  logic             flip_evt;

  assign raw_s    = sync_q[1];
  assign cnt_inc  = cnt_q + 1'b1;
  assign lim      = line_ok ? CNT_W'(DOWN_MS) : CNT_W'(UP_MS);
  assign flip_evt = (raw_s != line_ok) && tick && (cnt_inc >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      cnt_q   <= '0;
      line_ok <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (raw_s == line_ok) begin
        cnt_q <= '0;
      end else if (flip_evt) begin
        line_ok <= raw_s;
        cnt_q   <= '0;
      end else if (tick) begin
        cnt_q <= cnt_inc;
      end
    end
  end

  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (line_ok != $past(line_ok)) |-> $past(tick)); // R1
  AST_LINE_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (line_ok != $past(line_ok)) |-> (line_ok == $past(raw_s))); // R2

endmodule

// File: rtl/xfer_window.sv
module xfer_window
  import xfer_pkg::*;
#(
  parameter int SAMP_W     = 12,
  parameter int TS_W       = 16,
  parameter int HOLD_MS    = 50,
  parameter int MAX_MS     = 500,
  parameter int STABLE_PCT = 90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [TS_W-1:0]   ms_now,
  input  logic              start,
  input  logic              abort,
  input  logic [SAMP_W-1:0] iled,
  input  logic [SAMP_W-1:0] target,
  input  logic [SAMP_W-1:0] vbus,
  output logic              done,
  output logic              timeout,
  output logic [TS_W-1:0]   xfer_ms,
  output logic [SAMP_W-1:0] vbus_min,
  output logic              valid
);
  localparam int HW = $clog2(HOLD_MS + 1);
  localparam int EW = $clog2(MAX_MS + 1);

  logic            active, run;
  logic [HW-1:0]   hold_cnt;
  logic [EW-1:0]   elapsed;
  logic [TS_W-1:0] loss_ts, entry_ts;
  logic            in_band;

  assign in_band = band_ok(32'(iled), 32'(target), 32'(STABLE_PCT));
  assign done    = active && run && in_band && tick &&
                   ((hold_cnt + HW'(1)) >= HW'(HOLD_MS));
  assign timeout = active && !done && tick &&
                   ((elapsed + EW'(1)) >= EW'(MAX_MS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; run <= 1'b0; hold_cnt <= '0; elapsed <= '0;
      loss_ts <= '0; entry_ts <= '0; xfer_ms <= '0; vbus_min <= '0;
      valid <= 1'b0;
    end else if (start) begin
      active   <= 1'b1;
      loss_ts  <= ms_now;
      vbus_min <= vbus;
      run      <= 1'b0;
      hold_cnt <= '0;
      elapsed  <= '0;
      valid    <= 1'b0;
    end else begin
      if (active) begin
        if (vbus < vbus_min) vbus_min <= vbus;
        if (tick) elapsed <= elapsed + 1'b1;
        if (!in_band) begin
          run <= 1'b0; hold_cnt <= '0;
        end else if (!run) begin
          run <= 1'b1; entry_ts <= ms_now; hold_cnt <= '0;
        end else if (tick) begin
          hold_cnt <= hold_cnt + 1'b1;
        end
        if (done) begin
          valid   <= 1'b1;
          xfer_ms <= entry_ts - loss_ts;
          active  <= 1'b0;
        end
        if (timeout) active <= 1'b0;
      end
      if (abort) active <= 1'b0;
    end
  end

  AST_VMIN_NONRISING: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(start)) |-> (vbus_min <= $past(vbus_min))); // R6
  AST_VALID_NEEDS_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> ($past(in_band) && $past(run))); // R5

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int SAMP_W      = 12,
  parameter int TS_W        = 16,
  parameter int BO_W        = 8,
  parameter int TICK_DIV    = 125000,
  parameter int DOWN_MS     = 20,
  parameter int UP_MS       = 200,
  parameter int HOLD_MS     = 50,
  parameter int STABLE_PCT  = 90,
  parameter int MAX_XFER_MS = 500,
  parameter int BROWN_LVL   = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mains_raw,
  input  logic [SAMP_W-1:0] iled,
  input  logic [SAMP_W-1:0] iled_target,
  input  logic [SAMP_W-1:0] vbus,
  input  logic [3:0]        prot_flags,
  input  logic              test_req,
  input  logic              fault_clr,
  output logic              line_ok,
  output logic              xfer_en,
  output logic              inv_en,
  output logic [2:0]        mode,
  output logic [TS_W-1:0]   transfer_ms,
  output logic              xfer_valid,
  output logic [SAMP_W-1:0] vbus_min,
  output logic [BO_W-1:0]   brownout_cnt,
  output logic [4:0]        fault_bits
);
  logic            tick;
  logic [TS_W-1:0] ms_now;
  logic            win_start, win_abort, win_done, win_tmo;
  mode_t           mode_q, mode_nx;
  logic [FAULT_W-1:0] fault_q, fault_nx;
  logic            vbus_low, low_q, bo_evt;

  xfer_msclk #(.TICK_DIV(TICK_DIV), .TS_W(TS_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ms_now(ms_now));

  xfer_debounce #(.DOWN_MS(DOWN_MS), .UP_MS(UP_MS)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw(mains_raw), .line_ok(line_ok));

  xfer_window #(.SAMP_W(SAMP_W), .TS_W(TS_W), .HOLD_MS(HOLD_MS),
                .MAX_MS(MAX_XFER_MS), .STABLE_PCT(STABLE_PCT)) u_win (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ms_now(ms_now),
    .start(win_start), .abort(win_abort), .iled(iled), .target(iled_target),
    .vbus(vbus), .done(win_done), .timeout(win_tmo), .xfer_ms(transfer_ms),
    .vbus_min(vbus_min), .valid(xfer_valid));

  // fault latch: clear only when no flag is active, then merge new events
  always_comb begin
    fault_nx = fault_q;
    if (fault_clr && (prot_flags == '0)) fault_nx = '0;
    fault_nx[FB_TMO-1:0] = fault_nx[FB_TMO-1:0] | prot_flags;
    fault_nx[FB_TMO]     = fault_nx[FB_TMO] | win_tmo;
  end

  always_comb begin
    mode_nx = mode_q;
    unique case (mode_q)
      MODE_STANDBY: if (line_ok) mode_nx = MODE_NORMAL;
      MODE_NORMAL:  if (!line_ok) mode_nx = MODE_EMERG;
                    else if (test_req) mode_nx = MODE_TEST;
      MODE_EMERG:   if (line_ok) mode_nx = MODE_NORMAL;
      MODE_TEST:    if (!line_ok) mode_nx = MODE_EMERG;
                    else if (win_done) mode_nx = MODE_NORMAL;
      default:      mode_nx = MODE_STANDBY;
    endcase
    if (fault_nx != '0) mode_nx = MODE_FAULT;
  end

  assign win_start = ((mode_nx == MODE_EMERG) || (mode_nx == MODE_TEST)) &&
                     (mode_nx != mode_q);
  assign win_abort = !((mode_nx == MODE_EMERG) || (mode_nx == MODE_TEST));
  assign vbus_low  = (vbus < SAMP_W'(BROWN_LVL));
  assign bo_evt    = vbus_low && !low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= MODE_STANDBY;
      fault_q      <= '0;
      low_q        <= 1'b0;
      brownout_cnt <= '0;
    end else begin
      mode_q  <= mode_nx;
      fault_q <= fault_nx;
      low_q   <= vbus_low;
      if (bo_evt && (brownout_cnt != '1)) brownout_cnt <= brownout_cnt + 1'b1;
    end
  end

  assign mode       = mode_q;
  assign fault_bits = fault_q;
  assign xfer_en    = (mode_q == MODE_EMERG) || (mode_q == MODE_TEST);
  assign inv_en     = (mode_q == MODE_EMERG) || (mode_q == MODE_TEST);

  AST_NO_TEST_FROM_EMERG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_EMERG) |=> (mode_q != MODE_TEST)); // R8
  AST_TEST_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_TEST) && ($past(mode_q) != MODE_TEST)) |-> $past(line_ok)); // R8
  AST_FAULT_FORCES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q != '0) |-> (mode_q == MODE_FAULT)); // R9
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(fault_q) != '0) && !$past(fault_clr)) |->
      ((fault_q & $past(fault_q)) == $past(fault_q))); // R11
  AST_RESTORE_DEBOUNCED: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_NORMAL) && ($past(mode_q) == MODE_EMERG)) |-> $past(line_ok)); // R7
  AST_BROWNOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (brownout_cnt == $past(brownout_cnt)) ||
    (brownout_cnt == $past(brownout_cnt) + 1'b1)); // R12

endmodule

// File: tb/xfer_ctrl_test.sv
`timescale 1ns/1ps
module xfer_ctrl_test;
  localparam int DIV = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mains_raw = 1'b0;
  logic [11:0] iled = '0, iled_target = 12'd1000, vbus = 12'd900;
  logic [3:0]  prot_flags = '0;
  logic        test_req = 1'b0, fault_clr = 1'b0;
  logic        line_ok, xfer_en, inv_en, xfer_valid;
  logic [2:0]  mode;
  logic [15:0] transfer_ms;
  logic [11:0] vbus_min;
  logic [7:0]  brownout_cnt;
  logic [4:0]  fault_bits;

  int total = 0;
  int bad = 0;

  typedef struct { int lo; int hi; int vmin; string tag; } exp_t;
  exp_t sb_q[$];
  exp_t cur;
  logic prev_valid = 1'b0;

  always #4 clk = ~clk;

  xfer_ctrl #(.SAMP_W(12), .TS_W(16), .BO_W(8), .TICK_DIV(DIV), .DOWN_MS(3),
              .UP_MS(5), .HOLD_MS(4), .STABLE_PCT(90), .MAX_XFER_MS(30),
              .BROWN_LVL(700)) uut (
    .clk(clk), .rst_n(rst_n), .mains_raw(mains_raw), .iled(iled),
    .iled_target(iled_target), .vbus(vbus), .prot_flags(prot_flags),
    .test_req(test_req), .fault_clr(fault_clr), .line_ok(line_ok),
    .xfer_en(xfer_en), .inv_en(inv_en), .mode(mode), .transfer_ms(transfer_ms),
    .xfer_valid(xfer_valid), .vbus_min(vbus_min), .brownout_cnt(brownout_cnt),
    .fault_bits(fault_bits));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ms(input int n);
    repeat (n * DIV) @(negedge clk);
  endtask

  task automatic expect_xfer(input int lo, input int hi, input int vmin, input string tag);
    exp_t e;
    e.lo = lo; e.hi = hi; e.vmin = vmin; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic pulse_test();
    test_req = 1'b1; cyc(1); test_req = 1'b0;
  endtask

  task automatic pulse_clr();
    fault_clr = 1'b1; cyc(1); fault_clr = 1'b0;
  endtask

  // monitor: each completed transfer is compared against the next expected item
  always @(negedge clk) begin
    if (xfer_valid && !prev_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R5 unexpected transfer report", int'(transfer_ms), -1);
      end else begin
        cur = sb_q.pop_front();
        chk(int'(transfer_ms) >= cur.lo && int'(transfer_ms) <= cur.hi,
            {"R5 transfer_ms ", cur.tag}, int'(transfer_ms), cur.lo);
        chk(int'(vbus_min) == cur.vmin, {"R6 vbus_min ", cur.tag},
            int'(vbus_min), cur.vmin);
      end
    end
    prev_valid = xfer_valid;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    // R3 reset state
    chk(mode == 3'd1, "R3 mode", mode, 1);
    chk(!xfer_en && !inv_en && !line_ok && !xfer_valid, "R3 enables/line", xfer_en, 0);
    chk(fault_bits == 0 && brownout_cnt == 0, "R3 fault/brownout", fault_bits, 0);
    chk(transfer_ms == 0 && vbus_min == 0, "R3 result regs", transfer_ms, 0);

    // R2 / R4: mains appears, standby -> normal after up debounce
    mains_raw = 1'b1;
    ms(3);
    chk(mode == 3'd1 && !line_ok, "R2 up debounce not elapsed", mode, 1);
    ms(4);
    chk(line_ok, "R2 line_ok after up debounce", line_ok, 1);
    chk(mode == 3'd0, "R4 standby to normal", mode, 0);

    // R1: short dip ignored
    mains_raw = 1'b0; ms(1); mains_raw = 1'b1;
    ms(6);
    chk(mode == 3'd0 && line_ok && !xfer_en, "R1 short dip ignored", mode, 0);

    // real loss
    mains_raw = 1'b0;
    ms(1);
    chk(mode == 3'd0, "R1 loss before down debounce", mode, 0);
    for (int k = 0; k < 5 * DIV && mode != 3'd2; k++) cyc(1);
    chk(mode == 3'd2, "R4 emergency entry", mode, 2);
    chk(xfer_en && inv_en, "R4 enables in emergency", inv_en, 1);
    vbus = 12'd600; ms(1); vbus = 12'd800; ms(1);
    iled = 12'd899; ms(5);
    chk(!xfer_valid, "R5 below band never completes", xfer_valid, 0);
    pulse_test(); cyc(2);
    chk(mode == 3'd2, "R8 test ignored in emergency", mode, 2);
    iled = 12'd950; ms(2); iled = 12'd0; ms(1);
    chk(!xfer_valid, "R5 short spike not accepted", xfer_valid, 0);
    expect_xfer(9, 11, 600, "mains loss");
    iled = 12'd900; ms(7);
    chk(sb_q.size() == 0, "R5 transfer reported", sb_q.size(), 0);
    chk(brownout_cnt == 1, "R12 brownout after dip", brownout_cnt, 1);

    // R7 restore chatter
    mains_raw = 1'b1; ms(2); mains_raw = 1'b0; ms(2);
    chk(mode == 3'd2, "R7 chatter keeps emergency", mode, 2);
    mains_raw = 1'b1; ms(3);
    chk(mode == 3'd2, "R7 restore not yet debounced", mode, 2);
    ms(4);
    chk(mode == 3'd0 && !inv_en && !xfer_en, "R7 restore to normal", mode, 0);

    // R8 self-test pass
    iled = 12'd0;
    pulse_test(); cyc(1);
    chk(mode == 3'd3 && inv_en, "R8 self-test start", mode, 3);
    expect_xfer(2, 4, 800, "self-test");
    ms(3); iled = 12'd950; ms(7);
    chk(mode == 3'd0, "R8 self-test returns to normal", mode, 0);
    chk(sb_q.size() == 0, "R5 self-test reported", sb_q.size(), 0);

    // R10 timeout
    iled = 12'd0;
    pulse_test();
    ms(32);
    chk(fault_bits == 5'h10, "R10 timeout bit", fault_bits, 16);
    chk(mode == 3'd4 && !xfer_en && !inv_en, "R10 fault mode", mode, 4);

    // R11 clear
    pulse_clr(); cyc(3);
    chk(fault_bits == 0, "R11 clear accepted", fault_bits, 0);
    chk(mode == 3'd0, "R11 back to normal", mode, 0);

    // R9 protection latch
    prot_flags = 4'b0100; cyc(2); prot_flags = 4'b0000; cyc(2);
    chk(fault_bits == 5'h04, "R9 OCP latched", fault_bits, 4);
    chk(mode == 3'd4 && !inv_en, "R9 fault mode", mode, 4);
    prot_flags = 4'b0001; cyc(1);
    pulse_clr(); cyc(2);
    chk(fault_bits == 5'h05, "R11 clear ignored with flag active", fault_bits, 5);
    prot_flags = 4'b0000; cyc(1);
    mains_raw = 1'b0; ms(5);
    chk(mode == 3'd4 && !xfer_en, "R9 no transfer from fault", mode, 4);
    pulse_clr(); cyc(3);
    chk(fault_bits == 0 && mode == 3'd1, "R11 standby with line low", mode, 1);
    pulse_test(); cyc(3);
    chk(mode == 3'd1 && !inv_en, "R8 test ignored while line low", mode, 1);

    // R12 more brownouts, each held several cycles
    vbus = 12'd600; cyc(5); vbus = 12'd900; cyc(5);
    vbus = 12'd650; cyc(5); vbus = 12'd900; cyc(2);
    chk(brownout_cnt == 3, "R12 one count per crossing", brownout_cnt, 3);

    chk(sb_q.size() == 0, "R5 scoreboard drained", sb_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule